// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional jump should be taken. A four-bit condition code chooses one of sixteen tests, applied to the processor's carry, zero, sign, overflow and parity flags. The result is a single `taken` bit. A separate enable input forces that bit low when no conditional branch is being resolved.

The sixteen codes come in eight pairs. Each even code is a base test: a single flag, the unsigned "below-or-equal" test (carry OR zero), or a signed test built from sign XOR overflow. The odd code that follows an even code is the exact complement of that base test. Bit 0 of the code therefore acts as an invert bit. Bits 3:1 choose the base test.

The `LATENCY` parameter selects the output form. With `LATENCY` = 1 (the default), `taken` comes from a register that an asynchronous active-low reset clears. With `LATENCY` = 0, the output is purely combinational.

Top module: `cc_branch_eval`

## Requirements
- R1: Code 0 is taken when overflow is set. Code 1 is taken when overflow is clear.
- R2: Code 2 ("below", unsigned) is taken when carry is set. Code 3 is taken when carry is clear.
- R3: Code 4 ("equal") is taken when zero is set. Code 5 is taken when zero is clear.
- R4: Code 6 ("below or equal", unsigned) is taken when carry OR zero is set. Code 7 ("above") is taken only when both carry and zero are clear.
- R5: Code 8 is taken when sign is set. Code 9 is taken when sign is clear.
- R6: Code 10 is taken when parity is set, meaning even parity. Code 11 is taken when parity is clear.
- R7: Code 12 ("less", signed) is taken when sign differs from overflow. Code 13 ("greater or equal") is taken when they are equal.
- R8: Code 14 ("less or equal", signed) is taken when sign differs from overflow or zero is set. Code 15 ("greater") is taken otherwise.
- R9: For any flag values, every odd code gives the logical complement of the even code just below it.
- R10: While `en` is low, `taken` is low, whatever the code and flags.
- R11: With `LATENCY` = 1, `taken` shows the result for the inputs sampled at the previous rising clock edge. A change of input does not reach `taken` before that edge. Asserting reset drives `taken` low at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered output |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Evaluate enable; low forces not-taken |
| cond_sel | input | 4 | Condition code: bits 3:1 choose the base test, bit 0 inverts it |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_o | input | 1 | Overflow flag |
| flag_p | input | 1 | Parity flag (1 = even parity) |
| taken | output | 1 | Branch-taken decision |

## Verification
The assertions assume that `en`, `cond_sel` and the five flags are known, non-X values at every rising edge after reset. They also assume that these inputs change only between edges, so that each edge samples one complete set of inputs. The stimulus meets both conditions. It drives every input on the falling edge and never leaves an input undriven after reset. It then steps through all sixteen codes against all 32 flag combinations, once with the enable high and once with it low.

// File: rtl/cc_pkg.sv
package cc_pkg;

   localparam int CODE_W   = 4;
   localparam int PICK_W   = CODE_W - 1;
   localparam int NUM_BASE = 1 << PICK_W;

   // Base test chosen by code bits 3:1; the order follows the code numbering
   typedef enum logic [PICK_W-1:0] {
      BT_OVF      = 3'd0,
      BT_BELOW    = 3'd1,
      BT_EQUAL    = 3'd2,
      BT_BELOW_EQ = 3'd3,
      BT_NEG      = 3'd4,
      BT_PAR_EVEN = 3'd5,
      BT_LESS     = 3'd6,
      BT_LESS_EQ  = 3'd7
   } base_test_e;

   typedef struct packed {
      logic c;
      logic z;
      logic s;
      logic o;
      logic p;
   } flags_t;

endpackage

// File: rtl/cc_base_table.sv
module cc_base_table
   import cc_pkg::*;
(
   input  flags_t              fl,
   output logic [NUM_BASE-1:0] base
);
   logic signed_lt;

   always_comb begin
      signed_lt             = fl.s ^ fl.o;
      base                  = '0;
      base[BT_OVF]          = fl.o;
      base[BT_BELOW]        = fl.c;
      base[BT_EQUAL]        = fl.z;
      base[BT_BELOW_EQ]     = fl.c | fl.z;
      base[BT_NEG]          = fl.s;
      base[BT_PAR_EVEN]     = fl.p;
      base[BT_LESS]         = signed_lt;
      base[BT_LESS_EQ]      = signed_lt | fl.z;
   end
endmodule

// File: rtl/cc_polarity.sv
module cc_polarity #(
   parameter int NB     = 8,
   localparam int PW    = $clog2(NB)
) (
   input  logic [NB-1:0] base,
   input  logic [PW-1:0] pick,
   input  logic          invert,
   output logic          raw
);
   always_comb raw = base[pick] ^ invert;
endmodule

// File: rtl/cc_out_stage.sv
module cc_out_stage #(
   parameter int LATENCY = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic raw,
   output logic taken
);
   logic gated;
   always_comb gated = en & raw;

   generate
      if (LATENCY == 0) begin : g_comb
         always_comb taken = gated;
      end else begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) taken <= 1'b0;
            else        taken <= gated;
         end
      end
   endgenerate
endmodule

// File: rtl/cc_branch_eval.sv
module cc_branch_eval
   import cc_pkg::*;
#(
   parameter int LATENCY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [CODE_W-1:0] cond_sel,
   input  logic              flag_c,
   input  logic              flag_z,
   input  logic              flag_s,
   input  logic              flag_o,
   input  logic              flag_p,
   output logic              taken
);
   generate
      if (LATENCY < 0 || LATENCY > 1) begin : g_bad_latency
         $error("cc_branch_eval: LATENCY must be 0 or 1");
      end
      if (CODE_W != 4) begin : g_bad_code
         $error("cc_branch_eval: condition code must be 4 bits");
      end
   endgenerate

   flags_t              fl;
   logic [NUM_BASE-1:0] base;
   logic                raw;

   always_comb fl = '{c: flag_c, z: flag_z, s: flag_s, o: flag_o, p: flag_p};

   cc_base_table u_table (
      .fl   (fl),
      .base (base)
   );

   cc_polarity #(.NB(NUM_BASE)) u_pol (
      .base   (base),
      .pick   (cond_sel[CODE_W-1:1]),
      .invert (cond_sel[0]),
      .raw    (raw)
   );

   cc_out_stage #(.LATENCY(LATENCY)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .raw   (raw),
      .taken (taken)
   );
endmodule

// File: rtl/cc_branch_eval_chk.sv
module cc_branch_eval_chk #(
   parameter int LATENCY = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       en,
   input logic [3:0] cond_sel,
   input logic       flag_c,
   input logic       flag_z,
   input logic       flag_s,
   input logic       flag_o,
   input logic       flag_p,
   input logic       taken
);
   // q_* are the inputs that the value now on taken was computed from
   logic       q_live, q_en, q_c, q_z, q_s, q_o, q_p;
   logic [3:0] q_sel;

   generate
      if (LATENCY == 0) begin : g_direct
         always_comb begin
            q_live = 1'b1;
            q_en = en; q_sel = cond_sel;
            q_c = flag_c; q_z = flag_z; q_s = flag_s; q_o = flag_o; q_p = flag_p;
         end
      end else begin : g_delayed
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_live <= 1'b0; q_en <= 1'b0; q_sel <= '0;
               q_c <= 1'b0; q_z <= 1'b0; q_s <= 1'b0; q_o <= 1'b0; q_p <= 1'b0;
            end else begin
               q_live <= 1'b1; q_en <= en; q_sel <= cond_sel;
               q_c <= flag_c; q_z <= flag_z; q_s <= flag_s; q_o <= flag_o; q_p <= flag_p;
            end
         end
      end
   endgenerate

   p_first_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !q_live |-> !taken);
   p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (q_live && !q_en) |-> !taken);
   p_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (q_live && q_en && q_sel == 4'd0) |-> (taken == q_o));
   p_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (q_live && q_en && q_sel == 4'd2) |-> (taken == q_c));
   p_not_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (q_live && q_en && q_sel == 4'd5) |-> (taken == !q_z));
   p_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (q_live && q_en && q_sel == 4'd7) |-> (taken == !(q_c || q_z)));
   p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (q_live && q_en && q_sel == 4'd8) |-> (taken == q_s));
   p_parity_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (q_live && q_en && q_sel == 4'd11) |-> (taken == !q_p));
   p_less_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_live && q_en && q_sel == 4'd12) |-> (taken == (q_s != q_o)));
   p_greater_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (q_live && q_en && q_sel == 4'd15) |-> (taken == ((q_s == q_o) && !q_z)));
endmodule

bind cc_branch_eval cc_branch_eval_chk #(.LATENCY(LATENCY)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .cond_sel (cond_sel),
   .flag_c   (flag_c),
   .flag_z   (flag_z),
   .flag_s   (flag_s),
   .flag_o   (flag_o),
   .flag_p   (flag_p),
   .taken    (taken)
);

// File: tb/tb_cc_branch_eval.sv
module tb_cc_branch_eval;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [3:0] cond_sel = '0;
   logic       flag_c = 1'b0, flag_z = 1'b0, flag_s = 1'b0, flag_o = 1'b0, flag_p = 1'b0;
   logic       taken;

   always #10 clk = ~clk;   // 50 MHz

   cc_branch_eval dut (
      .clk(clk), .rst_n(rst_n), .en(en), .cond_sel(cond_sel),
      .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o),
      .flag_p(flag_p), .taken(taken)
   );

   typedef struct {
      logic       exp;
      logic [3:0] sel;
      logic [4:0] fl;
      logic       en;
      string      tag;
   } item_t;

   item_t sbq[$];
   int    checks = 0;
   int    fails  = 0;
   logic  prev_exp = 1'b0;

   // fl bits: [4]=carry [3]=zero [2]=sign [1]=overflow [0]=parity
   function automatic logic model(logic [3:0] sel, logic [4:0] fl, logic e);
      logic c, z, s, o, p, b;
      c = fl[4]; z = fl[3]; s = fl[2]; o = fl[1]; p = fl[0];
      case (sel[3:1])
         3'd0: b = o;
         3'd1: b = c;
         3'd2: b = z;
         3'd3: b = c | z;
         3'd4: b = s;
         3'd5: b = p;
         3'd6: b = (s != o);
         default: b = (s != o) | z;
      endcase
      if (sel[0]) b = !b;
      return e ? b : 1'b0;
   endfunction

   function automatic string tag_of(logic [3:0] sel, logic e);
      string t;
      if (!e) return "R10";
      case (sel[3:1])
         3'd0: t = "R1";
         3'd1: t = "R2";
         3'd2: t = "R3";
         3'd3: t = "R4";
         3'd4: t = "R5";
         3'd5: t = "R6";
         3'd6: t = "R7";
         default: t = "R8";
      endcase
      if (sel[0]) t = {t, "/R9"};
      return t;
   endfunction

   task automatic check(string tag, logic act, logic exp, string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   task automatic drive(logic [3:0] sel, logic [4:0] fl, logic e);
      item_t it;
      @(negedge clk);
      cond_sel = sel; en = e;
      {flag_c, flag_z, flag_s, flag_o, flag_p} = fl;
      it.exp = model(sel, fl, e); it.sel = sel; it.fl = fl; it.en = e;
      it.tag = tag_of(sel, e);
      sbq.push_back(it);
      #1;
      // R11: new inputs must not reach taken before the next edge
      check("R11", taken, prev_exp, "output moved before clock edge");
      prev_exp = it.exp;
   endtask

   // monitor: one result per rising edge, compared mid-high-phase
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            checks++;
            if (taken !== it.exp) begin
               fails++;
               $display("FAIL %s sel=%0d flags=%b en=%b: actual=%b expected=%b",
                        it.tag, it.sel, it.fl, it.en, taken, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R11", taken, 1'b0, "reset state");
      rst_n = 1'b1;
      @(negedge clk);
      check("R11", taken, 1'b0, "idle after reset");

      // R1..R9 sweep: every code against every flag combination
      for (int s = 0; s < 16; s++)
         for (int f = 0; f < 32; f++)
            drive(4'(s), 5'(f), 1'b1);
      // R10: enable low, same sweep
      for (int s = 0; s < 16; s++)
         for (int f = 0; f < 32; f++)
            drive(4'(s), 5'(f), 1'b0);

      // R11: asynchronous reset clears a taken result
      drive(4'd4, 5'b01000, 1'b1);
      @(posedge clk); #6;
      check("R11", taken, 1'b1, "taken before reset");
      rst_n = 1'b0;
      #1;
      check("R11", taken, 1'b0, "async reset clears output");
      @(negedge clk);
      en = 1'b0;
      rst_n = 1'b1;
      prev_exp = 1'b0;
      @(negedge clk);
      check("R11", taken, 1'b0, "after reset release");

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule